// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a register-mapped mailbox that lets a host processor hand a command to an embedded power-management controller and collect the answer. The host sees a small 32-bit word-addressed register space. It holds a command word, a status word, a source and a destination pointer, a four-word outbound data area and a four-word inbound data area. The host fills the outbound area and pointers first. It then writes the command word. That write marks the mailbox busy and pulses a doorbell toward the controller.

The controller side sees the latched command word, the pointers and the outbound data as flat buses. It posts reply words into the inbound area through its own write port. It finishes the command with a done pulse that carries an error flag and an 8-bit error code. Completion sets a flag in the status word. If bit 8 of the command asked for it, the completion also raises a host interrupt. Without that bit, the host polls the busy bit. The host clears the flag by writing one to it.

Top module: `hc_mailbox`

## Requirements
- R1: After reset, the status word reads 0, `h_irq` and `c_doorbell` are low, and `h_rdata` is 0.
- R2: A host write to the command word (word 0, byte offset 0x00) while idle latches the word onto `c_cmd`, provided its length field (bits 23:16) is at most 16. From the next cycle, status bit 0 (busy) reads 1 and `c_doorbell` is high for exactly one cycle.
- R3: A `c_done` pulse while busy does four things. It clears busy, loads status bit 1 (error) from `c_err`, and sets status bit 2 (completion flag). It also loads status bits 23:16 with `c_err_code` when `c_err` is high and with 0 otherwise.
- R4: `h_irq` is high exactly when the completion flag is set and bit 8 of the last accepted or rejected command word was 1.
- R5: Writing a 1 to status bit 2 clears the completion flag. Writing 0 there leaves it unchanged. A `c_done` in the same cycle as the clearing write leaves the flag set.
- R6: A command write while busy is ignored: `c_cmd` keeps its value and no doorbell is sent. Instead, the sticky overrun flag in status bit 3 is set. It clears only when the host writes 1 to status bit 3.
- R7: An accepted command clears the completion flag, the error bit and the error code.
- R8: A command write while idle whose length field exceeds 16 is rejected. Busy stays 0 and no doorbell is sent. The error bit is set with code 4 in bits 23:16, the completion flag is set, bit 8 of the word is taken as the interrupt request, and `c_cmd` is unchanged.
- R9: The source pointer (byte 0x08) and destination pointer (byte 0x0C) are host read/write. Their values drive `c_sptr` and `c_dptr`.
- R10: The outbound area at bytes 0x80–0x8F is host read/write. Word i appears on `c_wbuf[32*i+31:32*i]`.
- R11: The inbound area at bytes 0x90–0x9F is written only through `c_rb_we`/`c_rb_idx`/`c_rb_data`, and the host reads it. Host writes to it have no effect.
- R12: `h_rdata` shows the addressed word in the cycle after `h_rd_en`. Unmapped word addresses read 0.
- R13: A `c_done` pulse while not busy leaves the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_wr_en | input | 1 | Host write strobe |
| h_rd_en | input | 1 | Host read strobe |
| h_waddr | input | 6 | Host word address (byte offset / 4) |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, valid one cycle after h_rd_en |
| h_irq | output | 1 | Completion interrupt to host |
| c_doorbell | output | 1 | One-cycle pulse toward controller on an accepted command |
| c_cmd | output | 32 | Latched command word |
| c_sptr | output | 32 | Source pointer |
| c_dptr | output | 32 | Destination pointer |
| c_wbuf | output | 128 | Outbound data words, word 0 in the low bits |
| c_rb_we | input | 1 | Controller write strobe for the inbound area |
| c_rb_idx | input | 2 | Inbound word index |
| c_rb_data | input | 32 | Inbound word data |
| c_done | input | 1 | Controller completion pulse |
| c_err | input | 1 | Error flag qualifying c_done |
| c_err_code | input | 8 | Error code qualifying c_done |

## Verification
The bench sends a second command while the first is still busy. A design that queued or overwrote that command would change `c_cmd` or ring the doorbell twice, where the correct design only sets the overrun flag. It raises `c_done` in the same cycle as a write-one-to-clear of the flag, and then with no command pending. These catch a clear that beats the set and a stray completion that sets the flag. It sends a length of 17 against one of exactly 16, and it reports a zero code on a successful completion. It also writes to the inbound area from the host side, which must be read-only there.

// File: rtl/hcmb_pkg.sv
package hcmb_pkg;
  localparam int DATA_W    = 32;
  localparam int AW        = 6;
  // status word bit positions
  localparam int ST_BUSY   = 0;
  localparam int ST_ERR    = 1;
  localparam int ST_FLAG   = 2;
  localparam int ST_OVR    = 3;
  localparam int ST_CODE   = 16;
  // command word fields
  localparam int CW_IRQ    = 8;
  localparam int CW_LEN    = 16;
  localparam int CODE_W    = 8;
  localparam logic [CODE_W-1:0] CODE_BAD_LEN = 8'd4;
  // word addresses
  localparam logic [AW-1:0] WA_CMD  = 6'h00;
  localparam logic [AW-1:0] WA_STS  = 6'h01;
  localparam logic [AW-1:0] WA_PTR0 = 6'h02;
  localparam logic [AW-1:0] WA_WBUF = 6'h20;
  localparam logic [AW-1:0] WA_RBUF = 6'h24;
endpackage

// File: rtl/hcmb_regfile.sv
module hcmb_regfile #(
  parameter int WORDS = 4,
  parameter int W     = 32,
  localparam int IW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [IW-1:0]      idx,
  input  logic [W-1:0]       wdata,
  output logic [WORDS*W-1:0] flat
);
  logic [W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_flat
    assign flat[g*W +: W] = mem[g];
  end

  assert_write_lands_R10: assert property (@(posedge clk) disable iff (rst)
    we |=> flat[$past(idx)*W +: W] == $past(wdata));
endmodule

// File: rtl/hcmb_cmd_ctrl.sv
module hcmb_cmd_ctrl
  import hcmb_pkg::*;
#(
  parameter int MAX_LEN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic              sts_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              c_done,
  input  logic              c_err,
  input  logic [CODE_W-1:0] c_err_code,
  output logic              busy,
  output logic              err,
  output logic              flag,
  output logic              ovr,
  output logic [CODE_W-1:0] code,
  output logic [DATA_W-1:0] cmd_q,
  output logic              doorbell,
  output logic              irq
);
  logic             msi_q;
  logic [7:0]       len;
  logic             len_bad;

  assign len     = wdata[CW_LEN +: 8];
  assign len_bad = (len > 8'(MAX_LEN));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; err <= 1'b0; flag <= 1'b0; ovr <= 1'b0;
      code <= '0; cmd_q <= '0; doorbell <= 1'b0; msi_q <= 1'b0;
    end else begin
      doorbell <= 1'b0;
      // write-one-to-clear first; sets below take priority
      if (sts_wr) begin
        if (wdata[ST_FLAG]) flag <= 1'b0;
        if (wdata[ST_OVR])  ovr  <= 1'b0;
      end
      if (cmd_wr) begin
        if (busy) begin
          ovr <= 1'b1;
        end else if (len_bad) begin
          err   <= 1'b1;
          code  <= CODE_BAD_LEN;
          flag  <= 1'b1;
          msi_q <= wdata[CW_IRQ];
        end else begin
          cmd_q    <= wdata;
          busy     <= 1'b1;
          doorbell <= 1'b1;
          err      <= 1'b0;
          code     <= '0;
          flag     <= 1'b0;
          msi_q    <= wdata[CW_IRQ];
        end
      end
      if (c_done && busy) begin
        busy <= 1'b0;
        err  <= c_err;
        code <= c_err ? c_err_code : '0;
        flag <= 1'b1;
      end
    end
  end

  assign irq = flag & msi_q;

  assert_accept_rings_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !busy && !len_bad) |=> (busy && doorbell && cmd_q == $past(wdata)));
  assert_doorbell_single_R2: assert property (@(posedge clk) disable iff (rst)
    doorbell |=> !doorbell);
  assert_done_completes_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && c_done) |=> (!busy && flag && err == $past(c_err)));
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && busy) |=> (ovr && $stable(cmd_q) && !doorbell));
  assert_flag_idle_R3: assert property (@(posedge clk) disable iff (rst)
    flag |-> !busy);
  assert_reject_len_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !busy && len_bad) |=> (!busy && err && code == CODE_BAD_LEN && !doorbell));
  assert_idle_done_R13: assert property (@(posedge clk) disable iff (rst)
    (c_done && !busy && !cmd_wr && !sts_wr) |=> ($stable(flag) && $stable(err) && $stable(code)));
endmodule

// File: rtl/hc_mailbox.sv
module hc_mailbox
  import hcmb_pkg::*;
#(
  parameter int BUF_WORDS = 4,
  localparam int IDX_W    = $clog2(BUF_WORDS),
  localparam int MAX_LEN  = BUF_WORDS * 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        h_wr_en,
  input  logic                        h_rd_en,
  input  logic [AW-1:0]               h_waddr,
  input  logic [DATA_W-1:0]           h_wdata,
  output logic [DATA_W-1:0]           h_rdata,
  output logic                        h_irq,
  output logic                        c_doorbell,
  output logic [DATA_W-1:0]           c_cmd,
  output logic [DATA_W-1:0]           c_sptr,
  output logic [DATA_W-1:0]           c_dptr,
  output logic [BUF_WORDS*DATA_W-1:0] c_wbuf,
  input  logic                        c_rb_we,
  input  logic [IDX_W-1:0]            c_rb_idx,
  input  logic [DATA_W-1:0]           c_rb_data,
  input  logic                        c_done,
  input  logic                        c_err,
  input  logic [CODE_W-1:0]           c_err_code
);
  localparam logic [AW-IDX_W-1:0] WB_TAG = WA_WBUF[AW-1:IDX_W];
  localparam logic [AW-IDX_W-1:0] RB_TAG = WA_RBUF[AW-1:IDX_W];

  logic hit_cmd, hit_sts, hit_ptr, hit_wb, hit_rb;
  assign hit_cmd = (h_waddr == WA_CMD);
  assign hit_sts = (h_waddr == WA_STS);
  assign hit_ptr = (h_waddr[AW-1:1] == WA_PTR0[AW-1:1]);
  assign hit_wb  = (h_waddr[AW-1:IDX_W] == WB_TAG);
  assign hit_rb  = (h_waddr[AW-1:IDX_W] == RB_TAG);

  logic              busy, err, flag, ovr;
  logic [CODE_W-1:0] code;

  hcmb_cmd_ctrl #(.MAX_LEN(MAX_LEN)) u_ctrl (
    .clk(clk), .rst(rst),
    .cmd_wr(h_wr_en && hit_cmd),
    .sts_wr(h_wr_en && hit_sts),
    .wdata(h_wdata),
    .c_done(c_done), .c_err(c_err), .c_err_code(c_err_code),
    .busy(busy), .err(err), .flag(flag), .ovr(ovr), .code(code),
    .cmd_q(c_cmd), .doorbell(c_doorbell), .irq(h_irq)
  );

  logic [2*DATA_W-1:0]         ptr_flat;
  logic [BUF_WORDS*DATA_W-1:0] rb_flat;

  hcmb_regfile #(.WORDS(2), .W(DATA_W)) u_ptr (
    .clk(clk), .rst(rst), .we(h_wr_en && hit_ptr),
    .idx(h_waddr[0]), .wdata(h_wdata), .flat(ptr_flat)
  );
  assign c_sptr = ptr_flat[0 +: DATA_W];
  assign c_dptr = ptr_flat[DATA_W +: DATA_W];

  hcmb_regfile #(.WORDS(BUF_WORDS), .W(DATA_W)) u_wbuf (
    .clk(clk), .rst(rst), .we(h_wr_en && hit_wb),
    .idx(h_waddr[IDX_W-1:0]), .wdata(h_wdata), .flat(c_wbuf)
  );

  hcmb_regfile #(.WORDS(BUF_WORDS), .W(DATA_W)) u_rbuf (
    .clk(clk), .rst(rst), .we(c_rb_we),
    .idx(c_rb_idx), .wdata(c_rb_data), .flat(rb_flat)
  );

  logic [DATA_W-1:0] sts_word, rd_next;
  always_comb begin
    sts_word = '0;
    sts_word[ST_BUSY] = busy;
    sts_word[ST_ERR]  = err;
    sts_word[ST_FLAG] = flag;
    sts_word[ST_OVR]  = ovr;
    sts_word[ST_CODE +: CODE_W] = code;
  end

  always_comb begin
    rd_next = '0;
    if (hit_cmd)      rd_next = c_cmd;
    else if (hit_sts) rd_next = sts_word;
    else if (hit_ptr) rd_next = ptr_flat[h_waddr[0]*DATA_W +: DATA_W];
    else if (hit_wb)  rd_next = c_wbuf[h_waddr[IDX_W-1:0]*DATA_W +: DATA_W];
    else if (hit_rb)  rd_next = rb_flat[h_waddr[IDX_W-1:0]*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst)          h_rdata <= '0;
    else if (h_rd_en) h_rdata <= rd_next;
  end

  assert_rbuf_hostro_R11: assert property (@(posedge clk) disable iff (rst)
    (h_wr_en && hit_rb && !c_rb_we) |=> $stable(rb_flat));
  assert_irq_needs_flag_R4: assert property (@(posedge clk) disable iff (rst)
    h_irq |-> sts_word[ST_FLAG]);
endmodule

// File: tb/sim_hc_mailbox.sv
module sim_hc_mailbox;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         h_wr_en = 0, h_rd_en = 0;
  logic [5:0]   h_waddr = '0;
  logic [31:0]  h_wdata = '0;
  logic [31:0]  h_rdata;
  logic         h_irq, c_doorbell;
  logic [31:0]  c_cmd, c_sptr, c_dptr;
  logic [127:0] c_wbuf;
  logic         c_rb_we = 0;
  logic [1:0]   c_rb_idx = '0;
  logic [31:0]  c_rb_data = '0;
  logic         c_done = 0, c_err = 0;
  logic [7:0]   c_err_code = '0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  hc_mailbox u0 (.*);

  task automatic chk(string req, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic hwr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); h_wr_en = 1; h_waddr = a; h_wdata = d;
    @(negedge clk); h_wr_en = 0;
  endtask

  task automatic hrd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); h_rd_en = 1; h_waddr = a;
    @(negedge clk); h_rd_en = 0; d = h_rdata;
  endtask

  task automatic cdone(logic e, logic [7:0] cd);
    @(negedge clk); c_done = 1; c_err = e; c_err_code = cd;
    @(negedge clk); c_done = 0; c_err = 0; c_err_code = '0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 irq", h_irq, 0);
    chk("R1 doorbell", c_doorbell, 0);
    chk("R1 rdata", h_rdata, 0);
    hrd(6'h01, v); chk("R1 status", v, 0);
  endtask

  task automatic t_accept_irq;
    logic [31:0] v;
    hwr(6'h00, 32'h0000_0142);
    chk("R2 doorbell", c_doorbell, 1);
    chk("R2 c_cmd", c_cmd, 32'h0000_0142);
    @(negedge clk); chk("R2 doorbell one cycle", c_doorbell, 0);
    hrd(6'h01, v); chk("R2 busy", v, 32'h1);
    hrd(6'h00, v); chk("R12 cmd readback", v, 32'h0000_0142);
    cdone(0, 8'h00);
    hrd(6'h01, v); chk("R3 done ok", v, 32'h4);
    chk("R4 irq on msi", h_irq, 1);
    hwr(6'h01, 32'h0); hrd(6'h01, v); chk("R5 write 0 keeps flag", v, 32'h4);
    hwr(6'h01, 32'h4); hrd(6'h01, v); chk("R5 w1c", v, 32'h0);
    chk("R4 irq cleared", h_irq, 0);
  endtask

  task automatic t_error_then_clear;
    logic [31:0] v;
    hwr(6'h00, 32'h0004_0010);
    cdone(1, 8'h06);
    hrd(6'h01, v); chk("R3 error code", v, 32'h0006_0006);
    chk("R4 no irq without msi", h_irq, 0);
    hwr(6'h00, 32'h0000_0033);
    hrd(6'h01, v); chk("R7 new cmd clears error", v, 32'h1);
    cdone(0, 8'h05);
    hrd(6'h01, v); chk("R3 code zero when ok", v, 32'h4);
  endtask

  task automatic t_overrun;
    logic [31:0] v;
    hwr(6'h00, 32'h0000_0011);
    hwr(6'h00, 32'h0000_0022);
    chk("R6 no doorbell", c_doorbell, 0);
    chk("R6 cmd kept", c_cmd, 32'h0000_0011);
    hrd(6'h01, v); chk("R6 overrun set", v, 32'h9);
    cdone(0, 8'h0);
    hrd(6'h01, v); chk("R6 overrun sticky", v, 32'hC);
    hwr(6'h01, 32'h8); hrd(6'h01, v); chk("R6 overrun w1c", v, 32'h4);
    hwr(6'h01, 32'h4);
  endtask

  task automatic t_same_cycle;
    logic [31:0] v;
    hwr(6'h00, 32'h0000_0044);
    @(negedge clk);
    h_wr_en = 1; h_waddr = 6'h01; h_wdata = 32'h4; c_done = 1;
    @(negedge clk); h_wr_en = 0; c_done = 0;
    hrd(6'h01, v); chk("R5 done wins over clear", v, 32'h4);
    hwr(6'h01, 32'h4);
  endtask

  task automatic t_reject;
    logic [31:0] v;
    hwr(6'h00, 32'h0011_0100);
    chk("R8 no doorbell", c_doorbell, 0);
    chk("R8 cmd unchanged", c_cmd, 32'h0000_0044);
    hrd(6'h01, v); chk("R8 status", v, 32'h0004_0006);
    chk("R8 irq", h_irq, 1);
    hwr(6'h00, 32'h0010_0000);
    chk("R8 len 16 accepted", c_doorbell, 1);
    cdone(0, 8'h0); hwr(6'h01, 32'h4);
  endtask

  task automatic t_idle_done;
    logic [31:0] v;
    cdone(1, 8'h07);
    hrd(6'h01, v); chk("R13 idle done ignored", v, 32'h0);
  endtask

  task automatic t_ptrs_bufs;
    logic [31:0] v;
    hwr(6'h02, 32'h1111_2222); hwr(6'h03, 32'h3333_4444);
    chk("R9 sptr", c_sptr, 32'h1111_2222);
    chk("R9 dptr", c_dptr, 32'h3333_4444);
    hrd(6'h03, v); chk("R9 dptr read", v, 32'h3333_4444);
    for (int i = 0; i < 4; i++) hwr(6'h20 + 6'(i), 32'hA000_0000 + 32'(i));
    chk("R10 wbuf flat", c_wbuf, {32'hA000_0003, 32'hA000_0002, 32'hA000_0001, 32'hA000_0000});
    hrd(6'h22, v); chk("R10 wbuf read", v, 32'hA000_0002);
    @(negedge clk); c_rb_we = 1; c_rb_idx = 2'd2; c_rb_data = 32'hCAFE_F00D;
    @(negedge clk); c_rb_we = 0;
    hrd(6'h26, v); chk("R11 rbuf read", v, 32'hCAFE_F00D);
    hwr(6'h26, 32'h0BAD_0BAD);
    hrd(6'h26, v); chk("R11 host write ignored", v, 32'hCAFE_F00D);
    hrd(6'h05, v); chk("R12 unmapped", v, 32'h0);
    hrd(6'h30, v); chk("R12 unmapped high", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_accept_irq();
    t_error_then_clear();
    t_overrun();
    t_same_cycle();
    t_reject();
    t_idle_done();
    t_ptrs_bufs();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule